// File: doc/BRIEF.md
# SDRAM power-up and refresh sequencer

This block brings an SDRAM out of power-up and then keeps it refreshed. After reset it holds the command bus at NOP for a programmable power-up wait. It then issues one precharge-all and a programmable number of auto-refreshes. After that it writes the mode register with the word supplied by the surrounding controller and waits out the mode-register recovery time. Only then does it raise `init_done`, which hands the bus to the main controller.

In normal operation an interval timer sets one refresh as owed every `REFI_CYC` cycles. Owed refreshes are held in a small saturating counter, so a refresh that must wait for busy banks is not lost. `refresh_busy` tells the main controller to finish its work and report all banks idle. When the controller reports `banks_idle`, the sequencer serves every owed refresh back to back, spaced by the refresh cycle time. Every timing constant is a parameter in clock cycles, and each gap must be at least 2.

Command codes on `cmd`: 0 = NOP, 1 = precharge all banks, 2 = auto-refresh, 3 = mode-register set.

The states are:
- POWERUP: hold NOP until the power-up wait ends.
- PREALL: issue precharge-all.
- WAIT_RP: wait out the precharge time.
- INIT_REF: issue one initialization refresh.
- INIT_RFC: wait out the refresh time. Go back to INIT_REF, or go on to MODESET after the last initialization refresh.
- MODESET: issue the mode-register set.
- WAIT_RSC: wait out the mode-register recovery time.
- READY: go to REF when a refresh is owed and the banks are idle.
- REF: issue a periodic refresh.
- WAIT_RFC: wait out the refresh time. Go to REF when more refreshes are owed and the banks are still idle, otherwise go to READY.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted, and right after an asynchronous reset, `cmd` is 0 (NOP), `addr` is 0, and `init_done` and `refresh_busy` are 0.
- R2: After reset is released, `cmd` stays NOP until the POWERUP_CYC-th rising edge. At that edge `cmd` becomes 1 (precharge-all) for one cycle, and `addr` has only bit AP_BIT (10) set.
- R3: The first initialization refresh (code 2) follows the precharge-all by exactly T_RP cycles. INIT_REFRESHES refreshes are issued in total, each exactly T_RFC cycles after the one before, with only NOP in between.
- R4: Mode-register set (code 3) follows the last initialization refresh by exactly T_RFC cycles, and `addr` equals `mode_word` in that cycle.
- R5: `init_done` rises exactly T_RSC cycles after the mode-register set. It then stays high until reset. No precharge-all or mode-register set is issued while it is high.
- R6: The initialization sequence runs to completion regardless of `banks_idle`.
- R7: Once `init_done` is high, one refresh becomes owed every REFI_CYC cycles. With `banks_idle` held high, the first periodic refresh appears REFI_CYC+1 cycles after `init_done` rises, and later ones follow every REFI_CYC cycles.
- R8: A periodic refresh is issued only in a cycle where `banks_idle` was high at the previous edge. `refresh_busy` is high while any refresh is owed and through the T_RFC window of a periodic refresh, and low otherwise.
- R9: Up to MAX_POSTPONE owed refreshes are kept, and any owed beyond that are dropped. When `banks_idle` returns, the kept ones are issued back to back, exactly T_RFC apart.
- R10: `addr` is 0 in every cycle that carries a NOP or a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ADDR_W | Value written into the mode register |
| banks_idle | input | 1 | Main controller reports all banks idle |
| cmd | output | 2 | Command code (0 NOP, 1 precharge-all, 2 refresh, 3 mode set) |
| addr | output | ADDR_W | Address bus value for the current command |
| init_done | output | 1 | Initialization finished, bus belongs to the main controller |
| refresh_busy | output | 1 | Refresh owed or in progress |

## Verification
The bench builds the block with a power-up wait of 20 cycles, T_RP = 3, T_RFC = 5, T_RSC = 2, eight initialization refreshes, a refresh interval of 40 cycles and a postponement limit of 3. These short values let it check every command cycle of a full initialization, twice across a mid-run reset. They also let it hold the banks busy for five intervals, so that the owed count saturates. The bench then confirms that exactly three refreshes drain back to back before the next interval tick.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_PREALL  = 2'd1,
        CMD_REFRESH = 2'd2,
        CMD_MODESET = 2'd3
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        S_POWERUP  = 4'd0,
        S_PREALL   = 4'd1,
        S_WAIT_RP  = 4'd2,
        S_INIT_REF = 4'd3,
        S_INIT_RFC = 4'd4,
        S_MODESET  = 4'd5,
        S_WAIT_RSC = 4'd6,
        S_READY    = 4'd7,
        S_REF      = 4'd8,
        S_WAIT_RFC = 4'd9
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_wait_timer.sv
// Down-counter shared by every wait of the sequencer.
module seq_wait_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= W'(RESET_VAL);
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);
endmodule

// File: rtl/refi_tick_gen.sv
// Pulses once every PERIOD enabled cycles.
module refi_tick_gen #(
    parameter int PERIOD = 2078
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (enable) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assign tick = enable && (cnt == LAST);
endmodule

// File: rtl/refresh_debt_ctr.sv
// Saturating count of refreshes owed but not yet issued.
module refresh_debt_ctr #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic pending
);
    localparam int LW = $clog2(MAX_OWED + 1);
    localparam logic [LW-1:0] CAP = LW'(MAX_OWED);

    logic [LW-1:0] level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (add && !take) begin
            if (level != CAP) level <= level + 1'b1;
        end else if (take && !add) begin
            if (level != '0) level <= level - 1'b1;
        end
    end

    assign pending = (level != '0);
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int AP_BIT         = 10,
    parameter int POWERUP_CYC    = 26600,
    parameter int T_RP           = 3,
    parameter int T_RFC          = 9,
    parameter int T_RSC          = 2,
    parameter int INIT_REFRESHES = 8,
    parameter int REFI_CYC       = 2078,
    parameter int MAX_POSTPONE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              banks_idle,
    output logic [1:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              refresh_busy
);
    localparam int TMAX = imax(imax(POWERUP_CYC, T_RP), imax(T_RFC, T_RSC));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int NW   = $clog2(INIT_REFRESHES + 1);

    localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 2);
    localparam logic [TW-1:0] LD_RFC = TW'(T_RFC - 2);
    localparam logic [TW-1:0] LD_RSC = TW'(T_RSC - 2);
    localparam logic [NW-1:0] N_LAST = NW'(INIT_REFRESHES);
    localparam logic [ADDR_W-1:0] PREALL_ADDR = ADDR_W'(1) << AP_BIT;

    seq_state_e state, next_state;

    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          timer_done;
    logic          tick;
    logic          owed;
    logic          run_phase;
    logic [NW-1:0] init_cnt;

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_POWERUP;
        else        state <= next_state;
    end

    // ---- initialization refresh counter ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  init_cnt <= '0;
        else if (state == S_INIT_REF) init_cnt <= init_cnt + 1'b1;
    end

    // ---- transitions ----
    always_comb begin
        next_state = state;
        unique case (state)
            S_POWERUP:  if (timer_done) next_state = S_PREALL;
            S_PREALL:   next_state = S_WAIT_RP;
            S_WAIT_RP:  if (timer_done) next_state = S_INIT_REF;
            S_INIT_REF: next_state = S_INIT_RFC;
            S_INIT_RFC: if (timer_done)
                            next_state = (init_cnt == N_LAST) ? S_MODESET : S_INIT_REF;
            S_MODESET:  next_state = S_WAIT_RSC;
            S_WAIT_RSC: if (timer_done) next_state = S_READY;
            S_READY:    if (owed && banks_idle) next_state = S_REF;
            S_REF:      next_state = S_WAIT_RFC;
            S_WAIT_RFC: if (timer_done)
                            next_state = (owed && banks_idle) ? S_REF : S_READY;
            default:    next_state = S_POWERUP;
        endcase
    end

    // ---- outputs and timer loads ----
    always_comb begin
        cmd          = CMD_NOP;
        addr         = '0;
        timer_load   = 1'b0;
        timer_val    = '0;
        run_phase    = 1'b0;
        refresh_busy = owed;
        unique case (state)
            S_PREALL: begin
                cmd        = CMD_PREALL;
                addr       = PREALL_ADDR;
                timer_load = 1'b1;
                timer_val  = LD_RP;
            end
            S_INIT_REF: begin
                cmd        = CMD_REFRESH;
                timer_load = 1'b1;
                timer_val  = LD_RFC;
            end
            S_MODESET: begin
                cmd        = CMD_MODESET;
                addr       = mode_word;
                timer_load = 1'b1;
                timer_val  = LD_RSC;
            end
            S_READY: begin
                run_phase = 1'b1;
            end
            S_REF: begin
                cmd          = CMD_REFRESH;
                timer_load   = 1'b1;
                timer_val    = LD_RFC;
                run_phase    = 1'b1;
                refresh_busy = 1'b1;
            end
            S_WAIT_RFC: begin
                run_phase    = 1'b1;
                refresh_busy = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign init_done = run_phase;

    seq_wait_timer #(
        .W         (TW),
        .RESET_VAL (POWERUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_done)
    );

    refi_tick_gen #(
        .PERIOD (REFI_CYC)
    ) u_refi (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_phase),
        .tick   (tick)
    );

    refresh_debt_ctr #(
        .MAX_OWED (MAX_POSTPONE)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (tick),
        .take    (state == S_REF),
        .pending (owed)
    );
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int T_RFC  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] mode_word,
    input logic              banks_idle,
    input logic              init_done,
    input logic              refresh_busy
);
    localparam int GW = $clog2(T_RFC + 1);
    localparam logic [GW-1:0] GAP_MIN = GW'(T_RFC);

    logic [GW-1:0] gap;
    logic          seen_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap      <= '0;
            seen_ref <= 1'b0;
        end else if (cmd == 2'd2) begin
            gap      <= GW'(1);
            seen_ref <= 1'b1;
        end else if (gap != GAP_MIN) begin
            gap <= gap + 1'b1;
        end
    end

    // R2: each command lasts one cycle
    a_r2_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'd0) |=> (cmd == 2'd0));

    a_r2_prea_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> (addr[AP_BIT] == 1'b1));

    a_r4_mode_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd3) |-> (addr == mode_word));

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r5_no_init_cmd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == 2'd0 || cmd == 2'd2));

    a_r8_refresh_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cmd == 2'd2) |-> $past(banks_idle));

    a_r8_busy_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cmd == 2'd2) |-> refresh_busy);

    // R3 and R9: refreshes never closer than T_RFC
    a_r9_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2 && seen_ref) |-> (gap == GAP_MIN));

    a_r10_quiet_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd0 || cmd == 2'd2) |-> (addr == '0));
endmodule

bind sdram_init_refresh_seq sdr_seq_checker #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .T_RFC  (T_RFC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .addr         (addr),
    .mode_word    (mode_word),
    .banks_idle   (banks_idle),
    .init_done    (init_done),
    .refresh_busy (refresh_busy)
);

// File: tb/sdram_init_refresh_seq_test.sv
module sdram_init_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 12;
    localparam int PWR   = 20;
    localparam int TRP   = 3;
    localparam int TRFC  = 5;
    localparam int TRSC  = 2;
    localparam int NREF  = 8;
    localparam int REFI  = 40;
    localparam int MAXP  = 3;

    localparam logic [1:0] C_NOP = 2'd0, C_PRE = 2'd1, C_REF = 2'd2, C_MRS = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mode_word = '0;
    logic          banks_idle = 1'b0;
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic          init_done;
    logic          refresh_busy;

    int cyc;
    int n_chk = 0;
    int n_fail = 0;
    int bad_addr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sdram_init_refresh_seq #(
        .ADDR_W(AW), .AP_BIT(10), .POWERUP_CYC(PWR), .T_RP(TRP), .T_RFC(TRFC),
        .T_RSC(TRSC), .INIT_REFRESHES(NREF), .REFI_CYC(REFI), .MAX_POSTPONE(MAXP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .banks_idle(banks_idle),
        .cmd(cmd), .addr(addr), .init_done(init_done), .refresh_busy(refresh_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // advance to the next non-NOP command, then check code, cycle and address
    task automatic expect_cmd(input logic [1:0] ec, input int ecyc,
                              input logic [AW-1:0] ea, input string req);
        int guard = 0;
        @(negedge clk);
        while (cmd == C_NOP && guard < 2000) begin
            if (addr != '0) bad_addr++;
            @(negedge clk);
            guard++;
        end
        chk(cmd == ec, req, "command code", int'(cmd), int'(ec));
        chk(cyc == ecyc, req, "command cycle", cyc, ecyc);
        chk(addr == ea, req, "command address", int'(addr), int'(ea));
    endtask

    task automatic step_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd == C_NOP, "R1", "cmd in reset", int'(cmd), 0);
        chk(addr == '0, "R1", "addr in reset", int'(addr), 0);
        chk(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
        chk(refresh_busy == 1'b0, "R1", "busy in reset", int'(refresh_busy), 0);
    endtask

    // full initialization with banks_idle held low (R6)
    task automatic t_init(input logic [AW-1:0] mw, output int e_cyc);
        int base;
        mode_word  = mw;
        banks_idle = 1'b0;
        rst_n      = 1'b1;
        expect_cmd(C_PRE, PWR, 12'h400, "R2");
        base = PWR + TRP;
        for (int k = 0; k < NREF; k++)
            expect_cmd(C_REF, base + k*TRFC, '0, "R3 R6");
        expect_cmd(C_MRS, base + NREF*TRFC, mw, "R4");
        chk(init_done == 1'b0, "R5", "init_done at mode set", int'(init_done), 0);
        e_cyc = base + NREF*TRFC + TRSC;
        step_to(e_cyc - 1);
        chk(init_done == 1'b0, "R5", "init_done one cycle early", int'(init_done), 0);
        @(negedge clk);
        chk(init_done == 1'b1, "R5", "init_done rise", int'(init_done), 1);
        chk(refresh_busy == 1'b0, "R8", "busy right after init", int'(refresh_busy), 0);
        chk(bad_addr == 0, "R10", "nonzero addr on NOP", bad_addr, 0);
        banks_idle = 1'b1;
    endtask

    task automatic t_periodic(input int e_cyc, output int last_ref);
        int f;
        f = e_cyc + REFI + 1;
        step_to(f - 2);
        chk(refresh_busy == 1'b0, "R8", "busy before owed", int'(refresh_busy), 0);
        @(negedge clk);
        chk(refresh_busy == 1'b1, "R8", "busy once owed", int'(refresh_busy), 1);
        expect_cmd(C_REF, f, '0, "R7");
        expect_cmd(C_REF, f + REFI, '0, "R7");
        chk(init_done == 1'b1, "R5", "init_done held", int'(init_done), 1);
        last_ref = f + REFI;
    endtask

    task automatic t_postpone(input int last_ref);
        int x;
        int refs = 0;
        banks_idle = 1'b0;
        x = last_ref + 5*REFI + 20;
        while (cyc < x) begin
            @(negedge clk);
            if (cmd == C_REF) refs++;
        end
        chk(refs == 0, "R8", "refreshes while banks busy", refs, 0);
        chk(refresh_busy == 1'b1, "R8", "busy while owed", int'(refresh_busy), 1);
        banks_idle = 1'b1;
        expect_cmd(C_REF, x + 1,  '0, "R9");
        expect_cmd(C_REF, x + 6,  '0, "R9");
        expect_cmd(C_REF, x + 11, '0, "R9");
        step_to(x + 15);
        chk(refresh_busy == 1'b1, "R8", "busy in refresh window", int'(refresh_busy), 1);
        @(negedge clk);
        chk(refresh_busy == 1'b0, "R9", "busy after drain (cap)", int'(refresh_busy), 0);
        expect_cmd(C_REF, x + 20, '0, "R9");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(cmd == C_NOP, "R1", "cmd after async reset", int'(cmd), 0);
        chk(init_done == 1'b0, "R1", "init_done after reset", int'(init_done), 0);
        chk(refresh_busy == 1'b0, "R1", "busy after reset", int'(refresh_busy), 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int e1, e2, lr;
        t_reset_state();
        t_init(12'h032, e1);
        t_periodic(e1, lr);
        t_postpone(lr);
        t_reset_mid();
        t_init(12'h027, e2);
        t_periodic(e2, lr);
        summary();
    end
endmodule